// File: doc/BRIEF.md
# Page-Wrapping Word Address Counter

This block keeps the one word address that every access to a byte-wide non-volatile array uses. A serial front end loads it from the upper address bits carried in the device-select byte and the word-address byte that follows. It then steps the address after each byte. Bytes received for a write are stored in a one-page holding buffer, and the counter steps only within the current page. During reads the address steps across the whole array. Between transfers the counter keeps its value, so a later read with no address phase starts where the last access ended.

At the end of a write the front end sends a commit strobe. The block then scans the holding buffer once, in ascending in-page offset order. For every offset that received a byte, it presents the absolute array address and the data byte, one per cycle, to the array controller. Offsets that received no byte are skipped, so a partial page changes only the bytes that were sent. The block is busy for exactly one page worth of cycles, and it ignores all strobes while busy.

Top module: `page_wrap_addr_ctr`

## Requirements
- R1: After reset, `addr_o` is 0, `busy_o` is 0 and `upd_valid_o` is 0.
- R2: A load strobe sets `addr_o`, in the next cycle, to the low ADDR_W bits of {`dev_bits_i`, `word_byte_i`}. The device bits become the top ADDR_W-8 address bits, and any higher device bits are ignored.
- R3: A write strobe stores `wr_data_i` and increments only the low PAGE_W bits of `addr_o`, modulo 2**PAGE_W. The upper bits stay unchanged, so a write at the last offset of a page continues at offset 0 of the same page.
- R4: A read strobe increments the full address modulo 2**ADDR_W, crossing page boundaries, so that the last address is followed by 0.
- R5: With no accepted strobe, `addr_o` holds its value.
- R6: The holding buffer keeps one byte per in-page offset, plus a mark showing that the offset was written. A later write to the same offset replaces the earlier byte, which is the case when more than one page of bytes is sent.
- R7: A commit starts a scan. In the k-th cycle after the commit edge (k = 0..2**PAGE_W-1), `upd_valid_o` is 1 only if offset k was written. When it is 1, `upd_addr_o` = {page row, k} and `upd_data_o` is the last byte written at offset k.
- R8: `busy_o` is 1 for exactly the 2**PAGE_W scan cycles. While it is 1, the load, write, read and commit strobes have no effect. When the scan ends, all marks are cleared.
- R9: Strobes raised in the same cycle are resolved in a fixed priority order: load first, then write, then read, then commit. Only the highest one takes effect.
- R10: A commit with no marked offset does not start a scan, and `busy_o` stays 0.
- R11: A load discards all marked bytes that have not yet been committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load a new address |
| dev_bits_i | input | 3 | Page-select bits from the device-select byte |
| word_byte_i | input | 8 | Word-address byte |
| wr_byte_i | input | 1 | One write data byte received |
| wr_data_i | input | DATA_W | Write data byte |
| rd_inc_i | input | 1 | One read byte sent; step the address |
| commit_i | input | 1 | Start committing the holding buffer |
| addr_o | output | ADDR_W | Current word address |
| busy_o | output | 1 | Commit scan in progress |
| upd_valid_o | output | 1 | Update entry present this cycle |
| upd_addr_o | output | ADDR_W | Array address of the update |
| upd_data_o | output | DATA_W | Data byte of the update |

## Verification
The bench builds the block with ADDR_W = 10 and PAGE_W = 3, which gives 128 pages of 8 bytes. With these values, two device bits take part in the address and the third must be dropped. An 8-byte page wrap needs only a few writes, and the top address 0x3FF can be loaded directly, so the whole-array rollover can be checked in two read steps. The small page also keeps every commit scan to 8 observed cycles, so each scan can be compared entry by entry, including the skipped offsets.

// File: rtl/wac_pkg.sv
`timescale 1ns/1ps
package wac_pkg;
  typedef logic [15:0] wide_addr_t;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_WR   = 2'd2,
    CMD_RD   = 2'd3
  } cmd_e;

  // Step only the in-page field; page row is frozen.
  function automatic wide_addr_t page_step(wide_addr_t a, int unsigned pw);
    wide_addr_t m;
    m = (16'(1) << pw) - 16'(1);
    return (a & ~m) | ((a + 16'(1)) & m);
  endfunction

  // Step across the whole array and wrap to zero.
  function automatic wide_addr_t array_step(wide_addr_t a, int unsigned aw);
    return (a + 16'(1)) & ((16'(1) << aw) - 16'(1));
  endfunction

  // Device page bits go above the word byte; bits beyond the array are cut.
  function automatic wide_addr_t join_addr(logic [2:0] dev, logic [7:0] wb,
                                           int unsigned aw);
    return {5'd0, dev, wb} & ((16'(1) << aw) - 16'(1));
  endfunction
endpackage

// File: rtl/wac_arb.sv
`timescale 1ns/1ps
module wac_arb
  import wac_pkg::*;
(
  input  logic load_i,
  input  logic wr_i,
  input  logic rd_i,
  input  logic commit_i,
  input  logic busy_i,
  output cmd_e cmd_o,
  output logic commit_go_o
);
  always_comb begin
    cmd_o       = CMD_NONE;
    commit_go_o = 1'b0;
    if (!busy_i) begin
      if (load_i)        cmd_o = CMD_LOAD;
      else if (wr_i)     cmd_o = CMD_WR;
      else if (rd_i)     cmd_o = CMD_RD;
      else if (commit_i) commit_go_o = 1'b1;
    end
  end
endmodule

// File: rtl/wac_ptr.sv
`timescale 1ns/1ps
module wac_ptr
  import wac_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd_i,
  input  logic [2:0]        dev_bits_i,
  input  logic [7:0]        word_byte_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;
  wide_addr_t        addr_w;

  assign addr_w = 16'(addr_q);
  assign addr_o = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else begin
      case (cmd_i)
        CMD_LOAD: addr_q <= ADDR_W'(join_addr(dev_bits_i, word_byte_i, ADDR_W));
        CMD_WR:   addr_q <= ADDR_W'(page_step(addr_w, PAGE_W));
        CMD_RD:   addr_q <= ADDR_W'(array_step(addr_w, ADDR_W));
        default:  addr_q <= addr_q;
      endcase
    end
  end
endmodule

// File: rtl/wac_pagebuf.sv
`timescale 1ns/1ps
module wac_pagebuf
  import wac_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd_i,
  input  logic              commit_go_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              upd_valid_o,
  output logic [ADDR_W-1:0] upd_addr_o,
  output logic [DATA_W-1:0] upd_data_o
);
  localparam int PAGES = 1 << PAGE_W;
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic [DATA_W-1:0] mem_q [PAGES];
  logic [PAGES-1:0]  mark_q;
  logic [ROW_W-1:0]  row_q;
  logic [PAGE_W-1:0] idx_q;
  logic              busy_q;
  logic [PAGE_W-1:0] off_w;
  logic              scan_last_w;

  assign off_w       = addr_i[PAGE_W-1:0];
  assign scan_last_w = (idx_q == PAGE_W'(PAGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q <= '0;
      row_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (scan_last_w) begin
        busy_q <= 1'b0;
        mark_q <= '0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end else if (cmd_i == CMD_LOAD) begin
      mark_q <= '0;
    end else if (cmd_i == CMD_WR) begin
      mark_q[off_w] <= 1'b1;
      row_q         <= addr_i[ADDR_W-1:PAGE_W];
    end else if (commit_go_i && (|mark_q)) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!busy_q && cmd_i == CMD_WR) mem_q[off_w] <= data_i;
  end

  assign busy_o      = busy_q;
  assign upd_valid_o = busy_q & mark_q[idx_q];
  assign upd_addr_o  = {row_q, idx_q};
  assign upd_data_o  = mem_q[idx_q];
endmodule

// File: rtl/page_wrap_addr_ctr.sv
`timescale 1ns/1ps
module page_wrap_addr_ctr
  import wac_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [2:0]        dev_bits_i,
  input  logic [7:0]        word_byte_i,
  input  logic              wr_byte_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_inc_i,
  input  logic              commit_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              upd_valid_o,
  output logic [ADDR_W-1:0] upd_addr_o,
  output logic [DATA_W-1:0] upd_data_o
);
  cmd_e cmd_w;
  logic commit_go_w;
  logic ld_fire, wr_fire, rd_fire;

  assign ld_fire = (cmd_w == CMD_LOAD);
  assign wr_fire = (cmd_w == CMD_WR);
  assign rd_fire = (cmd_w == CMD_RD);

  wac_arb u_arb (
    .load_i     (load_i),
    .wr_i       (wr_byte_i),
    .rd_i       (rd_inc_i),
    .commit_i   (commit_i),
    .busy_i     (busy_o),
    .cmd_o      (cmd_w),
    .commit_go_o(commit_go_w)
  );

  wac_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd_w),
    .dev_bits_i (dev_bits_i),
    .word_byte_i(word_byte_i),
    .addr_o     (addr_o)
  );

  wac_pagebuf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd_w),
    .commit_go_i(commit_go_w),
    .addr_i     (addr_o),
    .data_i     (wr_data_i),
    .busy_o     (busy_o),
    .upd_valid_o(upd_valid_o),
    .upd_addr_o (upd_addr_o),
    .upd_data_o (upd_data_o)
  );
endmodule

// File: rtl/page_wrap_addr_ctr_chk.sv
`timescale 1ns/1ps
module page_wrap_addr_ctr_chk #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              upd_valid,
  input logic [ADDR_W-1:0] upd_addr,
  input logic              ld_fire,
  input logic              wr_fire,
  input logic              rd_fire,
  input logic              commit
);
  assert_wr_in_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])) &&
                (addr[PAGE_W-1:0] == PAGE_W'($past(addr[PAGE_W-1:0]) + 1'b1)));

  assert_rd_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> addr == ADDR_W'($past(addr) + 1'b1));

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_fire && !wr_fire && !rd_fire) |=> $stable(addr));

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(ld_fire || wr_fire || rd_fire));

  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit));

  assert_upd_in_scan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> busy);

  assert_upd_ascending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && upd_valid) |=> (!upd_valid ||
      (upd_addr[PAGE_W-1:0] > $past(upd_addr[PAGE_W-1:0]))));
endmodule

bind page_wrap_addr_ctr page_wrap_addr_ctr_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr_o),
  .busy     (busy_o),
  .upd_valid(upd_valid_o),
  .upd_addr (upd_addr_o),
  .ld_fire  (ld_fire),
  .wr_fire  (wr_fire),
  .rd_fire  (rd_fire),
  .commit   (commit_i)
);

// File: tb/page_wrap_addr_ctr_tb_top.sv
`timescale 1ns/1ps
module page_wrap_addr_ctr_tb_top;
  localparam int AW = 10;
  localparam int PW = 3;
  localparam int NP = 1 << PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic [2:0]    dev_bits_i = '0;
  logic [7:0]    word_byte_i = '0;
  logic          wr_byte_i = 1'b0;
  logic [7:0]    wr_data_i = '0;
  logic          rd_inc_i = 1'b0;
  logic          commit_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic          busy_o;
  logic          upd_valid_o;
  logic [AW-1:0] upd_addr_o;
  logic [7:0]    upd_data_o;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  bit   ev [NP];
  logic [7:0] ed [NP];

  always #10 clk = ~clk;

  page_wrap_addr_ctr #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .dev_bits_i(dev_bits_i),
    .word_byte_i(word_byte_i), .wr_byte_i(wr_byte_i), .wr_data_i(wr_data_i),
    .rd_inc_i(rd_inc_i), .commit_i(commit_i), .addr_o(addr_o), .busy_o(busy_o),
    .upd_valid_o(upd_valid_o), .upd_addr_o(upd_addr_o), .upd_data_o(upd_data_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [2:0] d, input logic [7:0] w);
    @(negedge clk); load_i = 1'b1; dev_bits_i = d; word_byte_i = w;
    @(negedge clk); load_i = 1'b0;
  endtask

  task automatic do_wr(input logic [7:0] v);
    @(negedge clk); wr_byte_i = 1'b1; wr_data_i = v;
    @(negedge clk); wr_byte_i = 1'b0;
  endtask

  task automatic do_rd();
    @(negedge clk); rd_inc_i = 1'b1;
    @(negedge clk); rd_inc_i = 1'b0;
  endtask

  task automatic clear_exp();
    for (int k = 0; k < NP; k++) begin ev[k] = 1'b0; ed[k] = 8'h00; end
  endtask

  // Full scan: entry k is seen in the k-th cycle after the commit edge (R7, R8)
  task automatic run_commit(input int row, input string tag);
    @(negedge clk); commit_i = 1'b1;
    @(negedge clk); commit_i = 1'b0;
    for (int k = 0; k < NP; k++) begin
      chk(busy_o == 1'b1, {tag, " R8 busy in scan"}, busy_o, 1);
      chk(upd_valid_o == ev[k], {tag, " R7 valid"}, upd_valid_o, ev[k]);
      if (ev[k]) begin
        chk(upd_addr_o == AW'(row * NP + k), {tag, " R7 addr"}, upd_addr_o, row * NP + k);
        chk(upd_data_o == ed[k], {tag, " R6 data"}, upd_data_o, ed[k]);
      end
      if (k < NP - 1) @(negedge clk);
    end
    @(negedge clk);
    chk(busy_o == 1'b0, {tag, " R8 busy ends"}, busy_o, 0);
    chk(upd_valid_o == 1'b0, {tag, " R8 no entry after scan"}, upd_valid_o, 0);
  endtask

  task automatic expect_no_scan(input string tag);
    @(negedge clk); commit_i = 1'b1;
    @(negedge clk); commit_i = 1'b0;
    chk(busy_o == 1'b0, tag, busy_o, 0);
    chk(upd_valid_o == 1'b0, tag, upd_valid_o, 0);
  endtask

  task automatic t_reset();
    chk(addr_o == '0, "R1 addr", addr_o, 0);
    chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
    chk(upd_valid_o == 1'b0, "R1 valid", upd_valid_o, 0);
  endtask

  task automatic t_load();
    do_load(3'b110, 8'hA5);
    chk(addr_o == 10'h2A5, "R2 load drops bit2", addr_o, 'h2A5);
    do_load(3'b001, 8'h3C);
    chk(addr_o == 10'h13C, "R2 load", addr_o, 'h13C);
  endtask

  task automatic t_write_wrap();
    do_load(3'b000, 8'h16);
    do_wr(8'hD0); chk(addr_o == 10'h017, "R3 step", addr_o, 'h017);
    do_wr(8'hD1); chk(addr_o == 10'h010, "R3 page wrap", addr_o, 'h010);
    do_wr(8'hD2); chk(addr_o == 10'h011, "R3 after wrap", addr_o, 'h011);
    clear_exp();
    ev[6] = 1; ed[6] = 8'hD0; ev[7] = 1; ed[7] = 8'hD1; ev[0] = 1; ed[0] = 8'hD2;
    run_commit(2, "partial");
    chk(addr_o == 10'h011, "R5 addr kept over scan", addr_o, 'h011);
  endtask

  task automatic t_overwrite();
    do_load(3'b000, 8'h20);
    for (int i = 0; i < NP + 1; i++) do_wr(8'h40 + 8'(i));
    chk(addr_o == 10'h021, "R3 over one page", addr_o, 'h021);
    clear_exp();
    for (int k = 0; k < NP; k++) begin ev[k] = 1; ed[k] = 8'h40 + 8'(k); end
    ed[0] = 8'h40 + 8'(NP);
    run_commit(4, "overwrite R6");
  endtask

  task automatic t_read();
    do_load(3'b011, 8'hFE);
    do_rd(); chk(addr_o == 10'h3FF, "R4 step", addr_o, 'h3FF);
    do_rd(); chk(addr_o == 10'h000, "R4 array wrap", addr_o, 0);
    do_load(3'b000, 8'h17);
    do_rd(); chk(addr_o == 10'h018, "R4 crosses page", addr_o, 'h018);
    repeat (5) @(negedge clk);
    chk(addr_o == 10'h018, "R5 idle hold", addr_o, 'h018);
  endtask

  task automatic t_busy_ignore();
    do_load(3'b000, 8'h30);
    do_wr(8'hAA);
    @(negedge clk); commit_i = 1'b1;
    @(negedge clk); commit_i = 1'b0;
    load_i = 1'b1; wr_byte_i = 1'b1; rd_inc_i = 1'b1;
    dev_bits_i = 3'b011; word_byte_i = 8'h77; wr_data_i = 8'h55;
    repeat (NP) @(negedge clk);
    load_i = 1'b0; wr_byte_i = 1'b0; rd_inc_i = 1'b0;
    chk(busy_o == 1'b0, "R8 scan length", busy_o, 0);
    chk(addr_o == 10'h031, "R8 strobes ignored", addr_o, 'h031);
    expect_no_scan("R8 marks cleared");
  endtask

  task automatic t_priority();
    do_load(3'b000, 8'h50);
    do_wr(8'h11);
    @(negedge clk); load_i = 1'b1; wr_byte_i = 1'b1; dev_bits_i = 3'b010; word_byte_i = 8'h08;
    @(negedge clk); load_i = 1'b0; wr_byte_i = 1'b0;
    chk(addr_o == 10'h208, "R9 load over write", addr_o, 'h208);
    expect_no_scan("R11 load discards bytes");
    do_load(3'b000, 8'h17);
    @(negedge clk); wr_byte_i = 1'b1; rd_inc_i = 1'b1; wr_data_i = 8'h9C;
    @(negedge clk); wr_byte_i = 1'b0; rd_inc_i = 1'b0;
    chk(addr_o == 10'h010, "R9 write over read", addr_o, 'h010);
    @(negedge clk); rd_inc_i = 1'b1; commit_i = 1'b1;
    @(negedge clk); rd_inc_i = 1'b0; commit_i = 1'b0;
    chk(addr_o == 10'h011, "R9 read over commit", addr_o, 'h011);
    chk(busy_o == 1'b0, "R9 commit lost", busy_o, 0);
    clear_exp(); ev[7] = 1; ed[7] = 8'h9C;
    run_commit(2, "single");
  endtask

  task automatic t_empty();
    expect_no_scan("R10 empty commit");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_write_wrap();
    t_overwrite();
    t_read();
    t_busy_ignore();
    t_priority();
    t_empty();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule